// File: doc/BRIEF.md
# Fused Store Dual-Dispatch Scheduler

This block is a small reservation station for fused store micro-ops. Rename writes one entry per store, holding both the address half (base and index register sources plus an immediate) and the data half (one register source). The entry stays whole in the scheduler. It is split only when it dispatches, and it dispatches twice: the address half goes to the address-generation port as soon as base and index are ready, and the data half goes to the store-data port once the data register is ready. Either half may go first. When both are ready, both may go in the same cycle.

Writeback tag broadcasts wake pending sources. Each port picks the oldest eligible entry by allocation order. A stall on a port keeps the offered half pending. A flush empties the scheduler. Allocation goes into the lowest free slot, and `full_o` reports that no slot is free.

Top module: `sdf_sched`

## Requirements
- R1: `full_o` is high exactly when all NUM_ENTRIES slots hold an entry. An allocation presented while `full_o` is high is dropped and never dispatches.
- R2: The address port offers an entry only when its base and index sources are ready. It does not wait for the data source.
- R3: The data port offers an entry only when its data source is ready. This dispatch is independent of the address half, which may already have gone or may still be pending.
- R4: A broadcast tag equal to a pending source tag marks that source ready from the next cycle. This includes a broadcast in the same cycle as the allocation that names the tag. A source presented with its ready flag set (unused sources included) needs no broadcast.
- R5: Each port offers the oldest eligible entry by allocation order, not by slot index. At most one entry is offered per port per cycle.
- R6: An entry whose operands are all ready offers both halves in the same cycle, one on each port.
- R7: While a port's stall input is high, the offered half stays offered and is not counted as dispatched.
- R8: Each half of an entry is accepted exactly once. The slot is freed only after both halves have been accepted.
- R9: `flush_i` removes all entries by the next cycle. An allocation in the flush cycle is dropped.
- R10: After reset the scheduler is empty: both port valids are low and `full_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| flush_i | input | 1 | Invalidate all entries |
| alloc_valid_i | input | 1 | Allocation request from rename |
| alloc_id_i | input | ID_W | Store identifier |
| alloc_tag_i | input | 3 x TAG_W | Source tags: [0] base, [1] index, [2] data |
| alloc_rdy_i | input | 3 | Source already ready, same index order |
| alloc_imm_i | input | IMM_W | Address immediate |
| full_o | output | 1 | No free slot |
| wb_valid_i | input | NUM_WB | Broadcast valid per lane |
| wb_tag_i | input | NUM_WB x TAG_W | Broadcast tag per lane |
| agu_valid_o | output | 1 | Address half offered |
| agu_id_o | output | ID_W | Store id of the address half |
| agu_base_tag_o | output | TAG_W | Base source tag |
| agu_idx_tag_o | output | TAG_W | Index source tag |
| agu_imm_o | output | IMM_W | Immediate |
| agu_stall_i | input | 1 | Address port cannot accept |
| std_valid_o | output | 1 | Data half offered |
| std_id_o | output | ID_W | Store id of the data half |
| std_data_tag_o | output | TAG_W | Data source tag |
| std_stall_i | input | 1 | Data port cannot accept |

## Verification
The hardest case to reach is an older entry that sits in a higher slot index than a younger one, because allocation always fills the lowest free slot. The stimulus builds this case in steps. It allocates two stores with data ready and address pending. It then wakes and retires the first so that slot 0 is freed, and allocates a third store into slot 0. Finally it wakes both remaining address halves in one cycle. At that point the older store in slot 1 must win the address port ahead of the younger one in slot 0.

// File: rtl/sdf_pkg.sv
package sdf_pkg;
  localparam int NUM_SRC  = 3;
  localparam int SRC_BASE = 0;
  localparam int SRC_IDX  = 1;
  localparam int SRC_DATA = 2;
endpackage

// File: rtl/sdf_entry.sv
module sdf_entry
  import sdf_pkg::*;
#(
  parameter int TAG_W  = 6,
  parameter int ID_W   = 4,
  parameter int IMM_W  = 8,
  parameter int NUM_WB = 2
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             flush_i,
  input  logic                             alloc_i,
  input  logic [NUM_SRC-1:0][TAG_W-1:0]    alloc_tag_i,
  input  logic [NUM_SRC-1:0]               alloc_rdy_i,
  input  logic [ID_W-1:0]                  alloc_id_i,
  input  logic [IMM_W-1:0]                 alloc_imm_i,
  input  logic [NUM_WB-1:0]                wb_valid_i,
  input  logic [NUM_WB-1:0][TAG_W-1:0]     wb_tag_i,
  input  logic                             addr_take_i,
  input  logic                             data_take_i,
  output logic                             valid_o,
  output logic                             addr_elig_o,
  output logic                             data_elig_o,
  output logic [NUM_SRC-1:0][TAG_W-1:0]    tag_o,
  output logic [ID_W-1:0]                  id_o,
  output logic [IMM_W-1:0]                 imm_o
);
  logic                          valid_q, a_fired_q, d_fired_q;
  logic [NUM_SRC-1:0]            rdy_q;
  logic [NUM_SRC-1:0][TAG_W-1:0] tag_q;
  logic [ID_W-1:0]               id_q;
  logic [IMM_W-1:0]              imm_q;
  logic [NUM_SRC-1:0]            hit_cur, hit_new;
  logic                          a_fired_n, d_fired_n;

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    always_comb begin
      hit_cur[s] = 1'b0;
      hit_new[s] = 1'b0;
      for (int w = 0; w < NUM_WB; w++) begin
        if (wb_valid_i[w] && wb_tag_i[w] == tag_q[s])       hit_cur[s] = 1'b1;
        if (wb_valid_i[w] && wb_tag_i[w] == alloc_tag_i[s]) hit_new[s] = 1'b1;
      end
    end
  end

  assign a_fired_n = a_fired_q | addr_take_i;
  assign d_fired_n = d_fired_q | data_take_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q   <= 1'b0;
      a_fired_q <= 1'b0;
      d_fired_q <= 1'b0;
      rdy_q     <= '0;
      tag_q     <= '0;
      id_q      <= '0;
      imm_q     <= '0;
    end else if (flush_i) begin
      valid_q <= 1'b0;
    end else if (alloc_i) begin
      valid_q   <= 1'b1;
      a_fired_q <= 1'b0;
      d_fired_q <= 1'b0;
      rdy_q     <= alloc_rdy_i | hit_new;
      tag_q     <= alloc_tag_i;
      id_q      <= alloc_id_i;
      imm_q     <= alloc_imm_i;
    end else if (valid_q) begin
      rdy_q     <= rdy_q | hit_cur;
      a_fired_q <= a_fired_n;
      d_fired_q <= d_fired_n;
      if (a_fired_n && d_fired_n) valid_q <= 1'b0;
    end
  end

  assign valid_o     = valid_q;
  assign addr_elig_o = valid_q & ~a_fired_q & rdy_q[SRC_BASE] & rdy_q[SRC_IDX];
  assign data_elig_o = valid_q & ~d_fired_q & rdy_q[SRC_DATA];
  assign tag_o       = tag_q;
  assign id_o        = id_q;
  assign imm_o       = imm_q;

  p_addr_once_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    a_fired_q |-> !addr_take_i);
  p_data_once_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    d_fired_q |-> !data_take_i);
  p_addr_ops_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_take_i |-> valid_q && rdy_q[SRC_BASE] && rdy_q[SRC_IDX]);
  p_data_op_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_take_i |-> valid_q && rdy_q[SRC_DATA]);
endmodule

// File: rtl/sdf_age_matrix.sv
module sdf_age_matrix #(
  parameter int N = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [N-1:0]        alloc_oh_i,
  output logic [N-1:0][N-1:0] older_o   // older_o[i][j]: i allocated before j
);
  logic [N-1:0][N-1:0] older_q;

  for (genvar i = 0; i < N; i++) begin : g_row
    for (genvar j = 0; j < N; j++) begin : g_col
      if (i == j) begin : g_diag
        assign older_o[i][j] = 1'b0;
      end else begin : g_off
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni)            older_q[i][j] <= 1'b0;
          else if (alloc_oh_i[i]) older_q[i][j] <= 1'b0;
          else if (alloc_oh_i[j]) older_q[i][j] <= 1'b1;
        end
        assign older_o[i][j] = older_q[i][j];
      end
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) older_q[i][i] <= 1'b0;
    end
  end
endmodule

// File: rtl/sdf_oldest_pick.sv
module sdf_oldest_pick #(
  parameter int N = 4
) (
  input  logic [N-1:0]        req_i,
  input  logic [N-1:0][N-1:0] older_i,
  output logic [N-1:0]        gnt_o
);
  for (genvar i = 0; i < N; i++) begin : g_gnt
    logic [N-1:0] beats;
    for (genvar j = 0; j < N; j++) begin : g_cmp
      assign beats[j] = req_i[j] & older_i[j][i];
    end
    assign gnt_o[i] = req_i[i] & ~|beats;
  end
endmodule

// File: rtl/sdf_sched.sv
module sdf_sched
  import sdf_pkg::*;
#(
  parameter int NUM_ENTRIES = 4,
  parameter int TAG_W       = 6,
  parameter int ID_W        = 4,
  parameter int IMM_W       = 8,
  parameter int NUM_WB      = 2
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          flush_i,
  input  logic                          alloc_valid_i,
  input  logic [ID_W-1:0]               alloc_id_i,
  input  logic [NUM_SRC-1:0][TAG_W-1:0] alloc_tag_i,
  input  logic [NUM_SRC-1:0]            alloc_rdy_i,
  input  logic [IMM_W-1:0]              alloc_imm_i,
  output logic                          full_o,
  input  logic [NUM_WB-1:0]             wb_valid_i,
  input  logic [NUM_WB-1:0][TAG_W-1:0]  wb_tag_i,
  output logic                          agu_valid_o,
  output logic [ID_W-1:0]               agu_id_o,
  output logic [TAG_W-1:0]              agu_base_tag_o,
  output logic [TAG_W-1:0]              agu_idx_tag_o,
  output logic [IMM_W-1:0]              agu_imm_o,
  input  logic                          agu_stall_i,
  output logic                          std_valid_o,
  output logic [ID_W-1:0]               std_id_o,
  output logic [TAG_W-1:0]              std_data_tag_o,
  input  logic                          std_stall_i
);
  localparam int N = NUM_ENTRIES;

  logic [N-1:0]                          valid, addr_elig, data_elig;
  logic [N-1:0]                          agu_gnt, std_gnt, alloc_oh;
  logic [N-1:0][NUM_SRC-1:0][TAG_W-1:0]  e_tag;
  logic [N-1:0][ID_W-1:0]                e_id;
  logic [N-1:0][IMM_W-1:0]               e_imm;
  logic [N-1:0][N-1:0]                   older;
  logic                                  alloc_go;

  assign full_o   = &valid;
  assign alloc_go = alloc_valid_i & ~full_o & ~flush_i;
  assign alloc_oh = alloc_go ? (~valid & (valid + N'(1))) : '0;

  for (genvar e = 0; e < N; e++) begin : g_ent
    sdf_entry #(
      .TAG_W(TAG_W), .ID_W(ID_W), .IMM_W(IMM_W), .NUM_WB(NUM_WB)
    ) u_ent (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .flush_i    (flush_i),
      .alloc_i    (alloc_oh[e]),
      .alloc_tag_i(alloc_tag_i),
      .alloc_rdy_i(alloc_rdy_i),
      .alloc_id_i (alloc_id_i),
      .alloc_imm_i(alloc_imm_i),
      .wb_valid_i (wb_valid_i),
      .wb_tag_i   (wb_tag_i),
      .addr_take_i(agu_gnt[e] & ~agu_stall_i),
      .data_take_i(std_gnt[e] & ~std_stall_i),
      .valid_o    (valid[e]),
      .addr_elig_o(addr_elig[e]),
      .data_elig_o(data_elig[e]),
      .tag_o      (e_tag[e]),
      .id_o       (e_id[e]),
      .imm_o      (e_imm[e])
    );
  end

  sdf_age_matrix #(.N(N)) u_age (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .alloc_oh_i(alloc_oh),
    .older_o   (older)
  );

  sdf_oldest_pick #(.N(N)) u_pick_agu (.req_i(addr_elig), .older_i(older), .gnt_o(agu_gnt));
  sdf_oldest_pick #(.N(N)) u_pick_std (.req_i(data_elig), .older_i(older), .gnt_o(std_gnt));

  always_comb begin
    agu_id_o       = '0;
    agu_base_tag_o = '0;
    agu_idx_tag_o  = '0;
    agu_imm_o      = '0;
    std_id_o       = '0;
    std_data_tag_o = '0;
    for (int e = 0; e < N; e++) begin
      if (agu_gnt[e]) begin
        agu_id_o       |= e_id[e];
        agu_base_tag_o |= e_tag[e][SRC_BASE];
        agu_idx_tag_o  |= e_tag[e][SRC_IDX];
        agu_imm_o      |= e_imm[e];
      end
      if (std_gnt[e]) begin
        std_id_o       |= e_id[e];
        std_data_tag_o |= e_tag[e][SRC_DATA];
      end
    end
  end

  assign agu_valid_o = |agu_gnt;
  assign std_valid_o = |std_gnt;

  p_one_agu_r5: assert property (@(posedge clk_i) disable iff (!rst_ni) $onehot0(agu_gnt));
  p_one_std_r5: assert property (@(posedge clk_i) disable iff (!rst_ni) $onehot0(std_gnt));
  p_agu_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    agu_valid_o && agu_stall_i && !flush_i |=> agu_valid_o);
  p_std_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    std_valid_o && std_stall_i && !flush_i |=> std_valid_o);
  p_flush_empty_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> !full_o && !agu_valid_o && !std_valid_o);
  p_full_stays_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o && !flush_i && !(agu_valid_o && !agu_stall_i) && !(std_valid_o && !std_stall_i)
    |=> full_o);
endmodule

// File: tb/sdf_sched_tb_top.sv
module sdf_sched_tb_top;
  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             flush_i = 1'b0;
  logic             alloc_valid_i = 1'b0;
  logic [3:0]       alloc_id_i = '0;
  logic [2:0][5:0]  alloc_tag_i = '0;
  logic [2:0]       alloc_rdy_i = '0;
  logic [7:0]       alloc_imm_i = '0;
  logic             full_o;
  logic [1:0]       wb_valid_i = '0;
  logic [1:0][5:0]  wb_tag_i = '0;
  logic             agu_valid_o, std_valid_o;
  logic [3:0]       agu_id_o, std_id_o;
  logic [5:0]       agu_base_tag_o, agu_idx_tag_o, std_data_tag_o;
  logic [7:0]       agu_imm_o;
  logic             agu_stall_i = 1'b0;
  logic             std_stall_i = 1'b0;
  int               n_chk = 0;
  int               n_err = 0;

  always #10 clk_i = ~clk_i;

  sdf_sched dut_i (
    .clk_i, .rst_ni, .flush_i, .alloc_valid_i, .alloc_id_i, .alloc_tag_i,
    .alloc_rdy_i, .alloc_imm_i, .full_o, .wb_valid_i, .wb_tag_i,
    .agu_valid_o, .agu_id_o, .agu_base_tag_o, .agu_idx_tag_o, .agu_imm_o,
    .agu_stall_i, .std_valid_o, .std_id_o, .std_data_tag_o, .std_stall_i
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc();
    @(posedge clk_i); #1;
    alloc_valid_i = 1'b0;
    wb_valid_i    = '0;
    flush_i       = 1'b0;
  endtask

  task automatic alloc(input int id, input int bt, input bit br, input int it, input bit ir,
                       input int dt, input bit dr, input int imm);
    alloc_valid_i  = 1'b1;
    alloc_id_i     = 4'(id);
    alloc_tag_i[0] = 6'(bt);
    alloc_tag_i[1] = 6'(it);
    alloc_tag_i[2] = 6'(dt);
    alloc_rdy_i    = {dr, ir, br};
    alloc_imm_i    = 8'(imm);
  endtask

  task automatic wake(input int lane, input int tag);
    wb_valid_i[lane] = 1'b1;
    wb_tag_i[lane]   = 6'(tag);
  endtask

  task automatic ports(input string req, input bit av, input int aid, input bit sv, input int sid);
    @(negedge clk_i);
    chk({req, " agu_valid"}, agu_valid_o, av);
    if (av) chk({req, " agu_id"}, agu_id_o, aid);
    chk({req, " std_valid"}, std_valid_o, sv);
    if (sv) chk({req, " std_id"}, std_id_o, sid);
  endtask

  task automatic t_reset();
    @(negedge clk_i);
    chk("R10 full", full_o, 0);
    chk("R10 agu_valid", agu_valid_o, 0);
    chk("R10 std_valid", std_valid_o, 0);
  endtask

  task automatic t_addr_first();
    alloc(1, 3, 1, 4, 1, 10, 0, 77);
    cyc();
    ports("R2 addr before data", 1, 1, 0, 0);
    chk("R2 imm", agu_imm_o, 77);
    chk("R2 base tag", agu_base_tag_o, 3);
    cyc();
    ports("R8 no refire", 0, 0, 0, 0);
    wake(0, 10);
    cyc();
    ports("R3 data after wake", 0, 0, 1, 1);
    chk("R3 data tag", std_data_tag_o, 10);
    cyc();
    ports("R8 freed", 0, 0, 0, 0);
  endtask

  task automatic t_alloc_wake();
    alloc(2, 5, 1, 6, 1, 11, 0, 0);
    wake(1, 11);
    cyc();
    ports("R4 R6 same-cycle wake", 1, 2, 1, 2);
    cyc();
    ports("R6 both done", 0, 0, 0, 0);
  endtask

  task automatic t_age();
    alloc(5, 40, 0, 1, 1, 2, 1, 0);
    cyc();
    ports("R3 data first", 0, 0, 1, 5);
    alloc(6, 41, 0, 1, 1, 2, 1, 0);
    cyc();
    ports("R5 data order", 0, 0, 1, 6);
    wake(0, 40);
    cyc();
    ports("R3 addr after data", 1, 5, 0, 0);
    cyc();
    ports("R8 P freed", 0, 0, 0, 0);
    alloc(8, 42, 0, 1, 1, 2, 1, 0);
    cyc();
    ports("R5 young data", 0, 0, 1, 8);
    wake(0, 41);
    wake(1, 42);
    cyc();
    ports("R5 older wins", 1, 6, 0, 0);
    cyc();
    ports("R5 younger next", 1, 8, 0, 0);
    cyc();
    ports("R5 drained", 0, 0, 0, 0);
  endtask

  task automatic t_stall();
    agu_stall_i = 1'b1;
    std_stall_i = 1'b1;
    alloc(9, 1, 1, 1, 1, 1, 1, 0);
    cyc();
    ports("R7 stalled offer", 1, 9, 1, 9);
    cyc();
    ports("R7 still held", 1, 9, 1, 9);
    agu_stall_i = 1'b0;
    cyc();
    ports("R7 agu taken std held", 0, 0, 1, 9);
    std_stall_i = 1'b0;
    cyc();
    ports("R7 std taken", 0, 0, 0, 0);
  endtask

  task automatic t_full_flush();
    for (int k = 0; k < 4; k++) begin
      alloc(10 + k, 60, 0, 1, 1, 61, 0, 0);
      cyc();
      @(negedge clk_i);
      chk("R1 full level", full_o, (k == 3) ? 1 : 0);
    end
    alloc(14, 1, 1, 1, 1, 1, 1, 0);
    cyc();
    ports("R1 drop when full", 0, 0, 0, 0);
    chk("R1 still full", full_o, 1);
    flush_i = 1'b1;
    cyc();
    @(negedge clk_i);
    chk("R9 not full", full_o, 0);
    wake(0, 60);
    wake(1, 61);
    cyc();
    ports("R9 flushed entries silent", 0, 0, 0, 0);
    flush_i = 1'b1;
    alloc(15, 1, 1, 1, 1, 1, 1, 0);
    cyc();
    ports("R9 alloc in flush dropped", 0, 0, 0, 0);
    chk("R9 empty", full_o, 0);
    alloc(3, 1, 1, 1, 1, 1, 1, 0);
    cyc();
    ports("R9 alloc after flush", 1, 3, 1, 3);
    cyc();
    ports("R8 idle", 0, 0, 0, 0);
  endtask

  initial begin
    #(20 * 200000);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #35 rst_ni = 1'b1;
    cyc();
    t_reset();
    t_addr_first();
    t_alloc_wake();
    t_age();
    t_stall();
    t_full_flush();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule